// File: doc/BRIEF.md
# Signed Fixed-Point to Single-Precision Float Converter

This block turns a signed 16-bit fixed-point number into a 32-bit IEEE 754 single-precision word. The input is read as two's complement, with the binary point six places from the right, so the input value is the signed integer reading divided by 64. Each clock edge captures one conversion. The matching float word appears on the output register one cycle after the input is presented.

The datapath first splits the input into a sign and an unsigned magnitude. A priority encoder then locates the highest set bit of the magnitude, and that position gives the biased exponent. A normalizing left shift places the bits below the leading one at the top of the fraction field. At most fifteen significant bits lie below the leading one, so every input is represented exactly. Rounding toward zero therefore never has to drop a bit. A zero input takes a separate path and produces the all-zero word. The most negative input is handled by treating the magnitude as unsigned.

Top module: `fix2float_conv`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `float_out` becomes 32'h0000_0000 and stays there until reset is released.
- R2: For a nonzero input, `float_out[31]` equals `fixed_in[15]`: 1 for negative values, 0 for positive values.
- R3: For a nonzero input, `float_out[30:23]` equals p + 121, where p is the bit index (0 to 15) of the highest set bit of the input's absolute value. The exponent therefore always lies between 121 and 136.
- R4: For a nonzero input, the bits of the absolute value below its highest set bit appear in `float_out[22:0]` starting at bit 22 and going downward. The highest set bit itself is not stored, and all lower fraction bits are 0, so bits 7:0 are always 0.
- R5: An input of 16'h0000 produces 32'h0000_0000.
- R6: The most negative input 16'h8000 (−512.0) produces 32'hC400_0000 (sign 1, exponent 136, fraction 0).
- R7: The result for an input appears on `float_out` at the first rising clock edge after the input is applied, and stays unchanged until the next edge.
- R8: The conversion is exact. The output word, read as a float, equals the input integer divided by 64 (for example 16'h30E9 gives 32'h4343_A400). Two inputs of equal magnitude and opposite sign give words that differ only in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fixed_in | input | 16 | Two's complement input with 10 integer and 6 fraction bits |
| float_out | output | 32 | Registered single-precision result |

## Verification
The bench builds the block with its default parameters: 16 input bits, 6 fraction bits, an 8-bit exponent and a 23-bit fraction. With these values the whole input range is small enough to sweep densely. The sweep reaches every leading-one position from 0 to 15, and with it every exponent from 121 to 136. It also covers the edge cases: the all-ones fraction at the positive maximum, the single-bit fraction at −1/64, the unsigned-magnitude path at 16'h8000, and the separate zero path. Expected words come from the bench's own real-number conversion and do not reuse the block's bit-level algorithm.

// File: rtl/f2f_pkg.sv
package f2f_pkg;

    // Exponent bias for a given exponent field width.
    function automatic int exp_bias(input int exp_w);
        return (1 << (exp_w - 1)) - 1;
    endfunction

    // Number of bits needed to hold an index below n.
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/f2f_sign_mag.sv
// Splits a two's complement word into a sign flag and an unsigned magnitude.
// The magnitude is unsigned and has the same width as the input, so the most
// negative input (only the top bit set) maps onto itself and is still exact.
module f2f_sign_mag #(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0] word_in,
    output logic            neg_out,
    output logic [IN_W-1:0] mag_out
);
    always_comb begin
        neg_out = word_in[IN_W-1];
        if (word_in[IN_W-1]) begin
            mag_out = (~word_in) + IN_W'(1);
        end else begin
            mag_out = word_in;
        end
    end
endmodule

// File: rtl/f2f_lead_one.sv
// Priority encoder: gives the index of the highest set bit of vec_in.
// any_out is low when vec_in is all zeros, and then pos_out is 0.
module f2f_lead_one #(
    parameter int W     = 16,
    parameter int POS_W = 4
) (
    input  logic [W-1:0]     vec_in,
    output logic [POS_W-1:0] pos_out,
    output logic             any_out
);
    always_comb begin
        pos_out = '0;
        any_out = 1'b0;
        // Ascending scan: the last set bit seen is the highest one.
        for (int b = 0; b < W; b++) begin
            if (vec_in[b]) begin
                pos_out = POS_W'(b);
                any_out = 1'b1;
            end
        end
    end
endmodule

// File: rtl/f2f_norm_shift.sv
// Normalizing shifter: moves the leading one to the top bit position, drops
// it as the hidden bit, and packs the remaining bits at the top of the
// fraction field. The generate branch picks zero fill when the fraction is
// wider than the remaining bits, and truncation toward zero when it is not.
module f2f_norm_shift #(
    parameter int W     = 16,
    parameter int POS_W = 4,
    parameter int MAN_W = 23
) (
    input  logic [W-1:0]     mag_in,
    input  logic [POS_W-1:0] lead_pos,
    output logic [MAN_W-1:0] frac_out
);
    localparam int BELOW_W = W - 1;

    logic [W-1:0]       aligned;
    logic [BELOW_W-1:0] below;

    always_comb begin
        aligned = mag_in << (POS_W'(W - 1) - lead_pos);
        below   = aligned[BELOW_W-1:0];
    end

    generate
        if (MAN_W > BELOW_W) begin : g_pad
            localparam int PAD_W = MAN_W - BELOW_W;
            always_comb frac_out = {below, {PAD_W{1'b0}}};
        end else if (MAN_W == BELOW_W) begin : g_exact
            always_comb frac_out = below;
        end else begin : g_trunc
            always_comb frac_out = below[BELOW_W-1 -: MAN_W];
        end
    endgenerate
endmodule

// File: rtl/fix2float_conv.sv
module fix2float_conv #(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 6,
    parameter int EXP_W  = 8,
    parameter int MAN_W  = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IN_W-1:0]          fixed_in,
    output logic [EXP_W+MAN_W:0]     float_out
);
    import f2f_pkg::*;

    localparam int POS_W    = idx_bits(IN_W);
    localparam int BIAS     = exp_bias(EXP_W);
    localparam int EXP_BASE = BIAS - FRAC_W;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] frac;
    } flt_word_t;

    logic              neg_w;
    logic [IN_W-1:0]   mag_w;
    logic [POS_W-1:0]  pos_w;
    logic              any_w;
    logic [MAN_W-1:0]  frac_w;

    flt_word_t res_d, res_q;

    f2f_sign_mag #(.IN_W(IN_W)) u_sign_mag (
        .word_in (fixed_in),
        .neg_out (neg_w),
        .mag_out (mag_w)
    );

    f2f_lead_one #(.W(IN_W), .POS_W(POS_W)) u_lead_one (
        .vec_in  (mag_w),
        .pos_out (pos_w),
        .any_out (any_w)
    );

    f2f_norm_shift #(.W(IN_W), .POS_W(POS_W), .MAN_W(MAN_W)) u_norm_shift (
        .mag_in   (mag_w),
        .lead_pos (pos_w),
        .frac_out (frac_w)
    );

    // Next-value logic: zero takes its own path, otherwise assemble fields.
    always_comb begin
        res_d = '0;
        if (any_w) begin
            res_d.sign = neg_w;
            res_d.expo = EXP_W'(EXP_BASE) + EXP_W'(pos_w);
            res_d.frac = frac_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign float_out = res_q;
endmodule

// File: rtl/fix2float_conv_chk.sv
module fix2float_conv_chk #(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 6,
    parameter int EXP_W  = 8,
    parameter int MAN_W  = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [IN_W-1:0]      fixed_in,
    input logic [EXP_W+MAN_W:0] float_out
);
    localparam int OUT_W   = 1 + EXP_W + MAN_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MIN = BIAS - FRAC_W;
    localparam int EXP_MAX = BIAS - FRAC_W + IN_W - 1;
    localparam int LOW_Z   = (MAN_W > IN_W - 1) ? MAN_W - (IN_W - 1) : 1;
    localparam logic [IN_W-1:0]  MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] MOST_NEG_WORD =
        {1'b1, EXP_W'(EXP_MAX), {MAN_W{1'b0}}};

    logic       rst_seen_q = 1'b0;
    logic [1:0] live_q     = 2'd0;

    // R1: an edge taken under reset leaves a zero word for the next edge.
    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clear_R1: assert (float_out == '0);
        end
        rst_seen_q <= !rst_n;
        if (!rst_n) live_q <= 2'd0;
        else if (live_q != 2'd2) live_q <= live_q + 2'd1;
    end

    assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_in != '0) |=> (float_out[OUT_W-1] == $past(fixed_in[IN_W-1])));

    assert_exp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (float_out != '0) |->
        (int'(float_out[OUT_W-2 -: EXP_W]) >= EXP_MIN &&
         int'(float_out[OUT_W-2 -: EXP_W]) <= EXP_MAX));

    assert_low_frac_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (MAN_W > IN_W - 1) |-> (float_out[LOW_Z-1:0] == '0));

    assert_zero_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_in == '0) |=> (float_out == '0));

    assert_most_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_in == MOST_NEG) |=> (float_out == MOST_NEG_WORD));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd2 && $stable(fixed_in)) |=> $stable(float_out));
endmodule

bind fix2float_conv fix2float_conv_chk #(
    .IN_W(IN_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W), .MAN_W(MAN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fixed_in  (fixed_in),
    .float_out (float_out)
);

// File: tb/fix2float_conv_tb_top.sv
module fix2float_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fixed_in = 16'h0000;
    logic [31:0] float_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fix2float_conv dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fixed_in  (fixed_in),
        .float_out (float_out)
    );

    // Input word and expected result for each table entry.
    localparam int NV = 9;
    localparam logic [47:0] VEC [NV] = '{
        {16'h30E9, 32'h4343_A400},  // R3 R4 R8: 195.640625
        {16'h0040, 32'h3F80_0000},  // +1.0
        {16'hFFC0, 32'hBF80_0000},  // R2: -1.0
        {16'h0001, 32'h3C80_0000},  // R3: 1/64, exponent 121
        {16'hFFFF, 32'hBC80_0000},  // R2: -1/64
        {16'h7FFF, 32'h43FF_FE00},  // R4: full fraction
        {16'h8000, 32'hC400_0000},  // R6
        {16'h0000, 32'h0000_0000},  // R5
        {16'hFF00, 32'hC080_0000}   // -4.0
    };

    // Reference built from real arithmetic, independent of the bit algorithm.
    function automatic logic [31:0] ref_word(input logic [15:0] v);
        real         r;
        logic [63:0] b;
        logic [10:0] e;
        if (v == 16'h0000) return 32'h0;
        r = $itor($signed(v)) / 64.0;
        b = $realtobits(r);
        e = b[62:52] - 11'd1023 + 11'd127;
        return {b[63], e[7:0], b[51:29]};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic apply(input logic [15:0] v);
        @(negedge clk);
        fixed_in = v;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state, input ignored while in reset.
        fixed_in = 16'h30E9;
        repeat (3) @(negedge clk);
        check("R1", float_out, 32'h0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][47:32]);
            check("R8", float_out, VEC[i][31:0]);
            check("R8", ref_word(VEC[i][47:32]), VEC[i][31:0]);
        end

        // R3: every leading-one position, both signs.
        for (int p = 0; p < 15; p++) begin
            apply(16'(1 << p));
            check("R3", float_out, {1'b0, 8'(121 + p), 23'h0});
            apply(16'(-(1 << p)));
            check("R2", float_out, {1'b1, 8'(121 + p), 23'h0});
        end

        // R8: dense sweep, and sign symmetry.
        for (int k = 1; k < 3000; k++) begin
            logic [15:0] v;
            logic [31:0] pos_w;
            v = 16'(k * 10 + (k % 7));
            apply(v);
            check("R8", float_out, ref_word(v));
            pos_w = float_out;
            if (v != 16'h8000) begin
                apply(-v);
                check("R8", float_out, {~pos_w[31], pos_w[30:0]});
            end
        end

        // R7: one-cycle latency and hold.
        apply(16'h0040);
        @(negedge clk);
        fixed_in = 16'hFFC0;
        #1 check("R7", float_out, 32'h3F80_0000);
        @(negedge clk);
        check("R7", float_out, 32'hBF80_0000);
        @(negedge clk);
        check("R7", float_out, 32'hBF80_0000);

        // R5 after a nonzero value, R6 again.
        apply(16'h0000);
        check("R5", float_out, 32'h0);
        apply(16'h8000);
        check("R6", float_out, 32'hC400_0000);

        // R1: reset clears a live result.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", float_out, 32'h0);
        rst_n = 1'b1;
        apply(16'h30E9);
        check("R8", float_out, 32'h4343_A400);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule